// File: doc/BRIEF.md
# External Bus Width and Endian Adapter

This block connects a 32-bit, big-endian internal access port to an external memory bus whose data width is set separately for each chip-select space: 8, 16 or 32 bits. A byte, word or longword request that is wider than the selected device becomes several back-to-back external cycles. The most significant part always goes first, at the lowest address. For each cycle the adapter drives the byte address, a one-hot active-low chip select and either a read strobe or per-lane active-low write strobes. It then places the data on the correct byte lanes, or takes it off them.

On a read, the data from each partial cycle is merged into a right-justified 32-bit result. A single done pulse marks it valid. A global endian enable, combined with a parameter mask of eligible spaces, reverses the byte lanes inside the device width. Little-endian devices and bus masters can then share data with the big-endian core. Each external cycle lasts one clock and then waits for an acknowledge from the device. Wait-state timing is therefore left to the device.

Top module: `bus_lane_adapter`

## Requirements
- R1: After reset, busy, done and err are low, every ext_cs_n bit and ext_rd_n are high, and ext_we_n is 4'hF.
- R2: Lane L is ext_dout/ext_din bits [8L+7:8L] and ext_we_n[L]. On a 16-bit space (width code 1), a big-endian byte at an even address uses lane 1 and at an odd address uses lane 0.
- R3: On a 16-bit space, a word (req_size 1) takes one cycle on lanes 1..0. A longword (req_size 2) takes two cycles: first at the base address carrying bits 31..16, then at base+2 carrying bits 15..0.
- R4: On an 8-bit space (width code 0), every cycle uses lane 0. A word takes two cycles at base and base+1 (bits 15..8 first). A longword takes four cycles at base..base+3, most significant byte first.
- R5: On a 32-bit space (width code 2 or 3), a big-endian access takes one cycle. The byte at address offset k sits on lane 3-k.
- R6: When cfg_le_en is 1 and the space's bit in LE_SPACES is 1, the lanes within the device width are reversed on both writes and reads.
- R7: Spaces whose LE_SPACES bit is 0 stay big-endian whatever cfg_le_en is.
- R8: An odd word address, a longword address with nonzero low two bits, or req_size 3 is rejected. err pulses for one clock, the clock after acceptance, no external cycle is issued and busy stays low.
- R9: A read returns the data right-justified in rdata (byte in [7:0], word in [15:0]). done pulses exactly once, one clock after the acknowledge of the last cycle.
- R10: Write cycles pull low only the ext_we_n bits of lanes carrying valid bytes, and drive zero on the other lanes. Read cycles pull ext_rd_n low with ext_we_n at 4'hF.
- R11: Each strobe lasts one clock. The next partial cycle's strobe appears the clock after the acknowledge is sampled, and never before.
- R12: busy rises the clock after an aligned request is accepted and falls with done. req_valid while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_width | input | 2*NUM_SPACES | Width code per space: 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| cfg_le_en | input | 1 | Endian enable for spaces marked in LE_SPACES |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 longword, 3 invalid |
| req_addr | input | ADDR_W | Byte address |
| req_space | input | log2(NUM_SPACES) | Target chip-select space |
| req_wdata | input | 32 | Right-justified write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | One-clock rejection pulse |
| rdata | output | 32 | Assembled read data |
| ext_addr | output | ADDR_W | External byte address of current cycle |
| ext_cs_n | output | NUM_SPACES | Active-low chip selects |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_we_n | output | 4 | Active-low per-lane write strobes |
| ext_dout | output | 32 | External write data |
| ext_din | input | 32 | External read data |
| ext_ack | input | 1 | Device acknowledge for the current cycle |

## Verification
The first strobe and any err pulse are due one clock after the accepting edge. Each later strobe is due one clock after the acknowledge is sampled, and done is due one clock after the last acknowledge. The bench drives and samples only on falling edges. Its device model stamps every strobe and acknowledge with a falling-edge count, so it can compare the gap between strobes with the programmed acknowledge delay plus two, and the distance from the last acknowledge to done with one. Lane contents, strobe patterns and addresses are compared per logged cycle against hand-derived values.

// File: rtl/bla_pkg.sv
// Shared types and lane-geometry helpers for the bus lane adapter.
// Assumes a 32-bit internal port, i.e. four byte lanes, lane 0 = bits 7..0.
package bla_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_t;

    // Map the raw width code to 0 (8), 1 (16) or 2 (32); code 3 means 32.
    function automatic logic [1:0] width_eff(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    // log2 of the bytes moved per external cycle.
    function automatic logic [1:0] unit_log(input logic [1:0] size, input logic [1:0] wcode);
        return (size < wcode) ? size : wcode;
    endfunction

    // Lowest big-endian lane used by a unit at offset off in the device word.
    function automatic logic [1:0] lane_pos(input logic [1:0] ulog, input logic [1:0] wcode,
                                            input logic [1:0] off);
        logic [2:0] wb;
        logic [2:0] mb;
        wb = 3'd1 << wcode;
        mb = 3'd1 << ulog;
        return 2'(wb - mb - {1'b0, off});
    endfunction

    // Data mask covering one unit, right-justified.
    function automatic logic [31:0] unit_keep(input logic [1:0] ulog);
        case (ulog)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Reverse byte lanes inside the device width.
    function automatic logic [31:0] rev_data(input logic [31:0] d, input logic [1:0] wcode);
        case (wcode)
            2'd0:    return d;
            2'd1:    return {d[31:16], d[7:0], d[15:8]};
            default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
        endcase
    endfunction

    // Reverse lane-enable bits inside the device width.
    function automatic logic [3:0] rev_mask(input logic [3:0] m, input logic [1:0] wcode);
        case (wcode)
            2'd0:    return m;
            2'd1:    return {m[3:2], m[0], m[1]};
            default: return {m[0], m[1], m[2], m[3]};
        endcase
    endfunction

endpackage

// File: rtl/bla_seq.sv
// Request sequencer: accepts one request when idle, rejects misaligned ones,
// then steps ISSUE (one-clock strobe) -> WAIT (for ack) per partial cycle.
// Assumes cyc_last is derived from the latched request and idx.
module bla_seq
    import bla_pkg::*;
#(
    parameter int ADDR_W  = 25,
    parameter int SPACE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [SPACE_W-1:0] req_space,
    input  logic [31:0]        req_wdata,
    input  logic               ext_ack,
    input  logic               cyc_last,
    output logic               busy,
    output logic               issue,
    output logic               done,
    output logic               err,
    output logic               capture,
    output logic               clear,
    output logic               lat_write,
    output logic [1:0]         lat_size,
    output logic [ADDR_W-1:0]  lat_addr,
    output logic [SPACE_W-1:0] lat_space,
    output logic [31:0]        lat_wdata,
    output logic [1:0]         cyc_idx
);

    seq_state_t state;
    logic       misalign;
    logic       accept;

    // Alignment and size legality of the incoming request.
    always_comb begin
        misalign = (req_size == 2'd3) ||
                   (req_size == 2'd1 && req_addr[0]) ||
                   (req_size == 2'd2 && req_addr[1:0] != 2'b00);
    end

    assign accept  = (state == ST_IDLE) && req_valid && !misalign;
    assign clear   = accept && !req_write;
    assign capture = (state == ST_WAIT) && ext_ack && !lat_write;
    assign busy    = (state != ST_IDLE);
    assign issue   = (state == ST_ISSUE);

    // State, request latch, partial-cycle index and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            done      <= 1'b0;
            err       <= 1'b0;
            lat_write <= 1'b0;
            lat_size  <= 2'd0;
            lat_addr  <= '0;
            lat_space <= '0;
            lat_wdata <= '0;
            cyc_idx   <= 2'd0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid && misalign) begin
                        err <= 1'b1;
                    end else if (accept) begin
                        lat_write <= req_write;
                        lat_size  <= req_size;
                        lat_addr  <= req_addr;
                        lat_space <= req_space;
                        lat_wdata <= req_wdata;
                        cyc_idx   <= 2'd0;
                        state     <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (ext_ack) begin
                        if (cyc_last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            cyc_idx <= cyc_idx + 2'd1;
                            state   <= ST_ISSUE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bla_lane_steer.sv
// Write-path steering: selects the unit of write data for the current partial
// cycle (most significant first) and places it on the device lanes, with an
// optional lane reversal. Purely combinational.
module bla_lane_steer
    import bla_pkg::*;
(
    input  logic [31:0] wdata,
    input  logic [1:0]  size,
    input  logic [1:0]  wcode,
    input  logic [1:0]  off,
    input  logic [1:0]  idx,
    input  logic [1:0]  cnt_m1,
    input  logic        le,
    output logic [31:0] lane_data,
    output logic [3:0]  lane_mask
);

    logic [1:0]  ulog;
    logic [1:0]  pos;
    logic [1:0]  units;
    logic [5:0]  chunk_sh;
    logic [31:0] chunk;
    logic [31:0] be_data;
    logic [3:0]  be_mask;
    logic [3:0]  unit_lanes;

    // Pick the unit for this cycle and shift it onto big-endian lanes.
    always_comb begin
        ulog  = unit_log(size, wcode);
        pos   = lane_pos(ulog, wcode, off);
        units = cnt_m1 - idx;
        case (ulog)
            2'd0:    chunk_sh = {1'b0, units, 3'b000};
            2'd1:    chunk_sh = {units, 4'b0000};
            default: chunk_sh = 6'd0;
        endcase
        chunk = (wdata >> chunk_sh) & unit_keep(ulog);
        case (ulog)
            2'd0:    unit_lanes = 4'b0001;
            2'd1:    unit_lanes = 4'b0011;
            default: unit_lanes = 4'b1111;
        endcase
        be_data = chunk << {pos, 3'b000};
        be_mask = unit_lanes << pos;
    end

    // Apply the optional lane reversal inside the device width.
    always_comb begin
        lane_data = le ? rev_data(be_data, wcode) : be_data;
        lane_mask = le ? rev_mask(be_mask, wcode) : be_mask;
    end

endmodule

// File: rtl/bla_read_gather.sv
// Read-path assembly: takes the unit off the device lanes on each
// acknowledged read cycle and shifts it into a right-justified accumulator.
// Assumes clear arrives before the first capture of a read.
module bla_read_gather
    import bla_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        capture,
    input  logic [31:0] din,
    input  logic [1:0]  size,
    input  logic [1:0]  wcode,
    input  logic [1:0]  off,
    input  logic        le,
    output logic [31:0] acc
);

    logic [1:0]  ulog;
    logic [1:0]  pos;
    logic [31:0] lanes;
    logic [31:0] chunk;
    logic [5:0]  acc_sh;
    logic [31:0] acc_n;

    // Undo lane reversal, extract the unit and merge it below older bytes.
    always_comb begin
        ulog   = unit_log(size, wcode);
        pos    = lane_pos(ulog, wcode, off);
        lanes  = le ? rev_data(din, wcode) : din;
        chunk  = (lanes >> {pos, 3'b000}) & unit_keep(ulog);
        acc_sh = 6'd8 << ulog;
        acc_n  = (acc << acc_sh) | chunk;
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc <= '0;
        else if (clear)   acc <= '0;
        else if (capture) acc <= acc_n;
    end

endmodule

// File: rtl/bus_lane_adapter.sv
// Top of the bus width and endian adapter. Resolves per-space width and
// endian mode, derives the partial-cycle count and address, and drives the
// external strobes. Assumes NUM_SPACES is a power of two and that cfg_*
// inputs are stable while busy.
module bus_lane_adapter
    import bla_pkg::*;
#(
    parameter int                  NUM_SPACES = 4,
    parameter int                  ADDR_W     = 25,
    parameter logic [NUM_SPACES-1:0] LE_SPACES = 4'b1100
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2*NUM_SPACES-1:0]       cfg_width,
    input  logic                          cfg_le_en,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [1:0]                    req_size,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [$clog2(NUM_SPACES)-1:0] req_space,
    input  logic [31:0]                   req_wdata,
    output logic                          busy,
    output logic                          done,
    output logic                          err,
    output logic [31:0]                   rdata,
    output logic [ADDR_W-1:0]             ext_addr,
    output logic [NUM_SPACES-1:0]         ext_cs_n,
    output logic                          ext_rd_n,
    output logic [LANES-1:0]              ext_we_n,
    output logic [31:0]                   ext_dout,
    input  logic [31:0]                   ext_din,
    input  logic                          ext_ack
);

    localparam int SPACE_W = $clog2(NUM_SPACES);

    logic               issue;
    logic               capture;
    logic               clear;
    logic               lat_write;
    logic [1:0]         lat_size;
    logic [ADDR_W-1:0]  lat_addr;
    logic [SPACE_W-1:0] lat_space;
    logic [31:0]        lat_wdata;
    logic [1:0]         cyc_idx;
    logic [1:0]         cnt_m1;
    logic               cyc_last;
    logic [1:0]         wcode;
    logic               le;
    logic [1:0]         wmask;
    logic [1:0]         off;
    logic [ADDR_W-1:0]  cyc_addr;
    logic [31:0]        lane_data;
    logic [3:0]         lane_mask;
    logic [1:0]         sp_w  [NUM_SPACES];
    logic               sp_le [NUM_SPACES];

    // Per-space width, endian mode and chip-select decode.
    for (genvar g = 0; g < NUM_SPACES; g++) begin : g_space
        assign sp_w[g]     = width_eff(cfg_width[2*g +: 2]);
        assign sp_le[g]    = cfg_le_en & LE_SPACES[g];
        assign ext_cs_n[g] = !(issue && (lat_space == SPACE_W'(g)));
    end

    // Cycle count, last-cycle flag, cycle address and offset in device word.
    always_comb begin
        wcode = sp_w[lat_space];
        le    = sp_le[lat_space];
        if (lat_size > wcode) cnt_m1 = (lat_size - wcode == 2'd1) ? 2'd1 : 2'd3;
        else                  cnt_m1 = 2'd0;
        cyc_last = (cyc_idx == cnt_m1);
        cyc_addr = lat_addr + (ADDR_W'(cyc_idx) << wcode);
        case (wcode)
            2'd0:    wmask = 2'b00;
            2'd1:    wmask = 2'b01;
            default: wmask = 2'b11;
        endcase
        off = cyc_addr[1:0] & wmask;
    end

    bla_seq #(.ADDR_W(ADDR_W), .SPACE_W(SPACE_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_space (req_space),
        .req_wdata (req_wdata),
        .ext_ack   (ext_ack),
        .cyc_last  (cyc_last),
        .busy      (busy),
        .issue     (issue),
        .done      (done),
        .err       (err),
        .capture   (capture),
        .clear     (clear),
        .lat_write (lat_write),
        .lat_size  (lat_size),
        .lat_addr  (lat_addr),
        .lat_space (lat_space),
        .lat_wdata (lat_wdata),
        .cyc_idx   (cyc_idx)
    );

    bla_lane_steer steer_i (
        .wdata     (lat_wdata),
        .size      (lat_size),
        .wcode     (wcode),
        .off       (off),
        .idx       (cyc_idx),
        .cnt_m1    (cnt_m1),
        .le        (le),
        .lane_data (lane_data),
        .lane_mask (lane_mask)
    );

    bla_read_gather gather_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .capture (capture),
        .din     (ext_din),
        .size    (lat_size),
        .wcode   (wcode),
        .off     (off),
        .le      (le),
        .acc     (rdata)
    );

    // External strobes and data, active only during the issue clock.
    always_comb begin
        ext_addr = cyc_addr;
        ext_rd_n = !(issue && !lat_write);
        ext_we_n = (issue && lat_write) ? ~lane_mask : 4'hF;
        ext_dout = (issue && lat_write) ? lane_data : 32'h0;
    end

endmodule

// File: rtl/bla_chk.sv
// Protocol checker for bus_lane_adapter, attached by bind.
module bla_chk #(
    parameter int NUM_SPACES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic                  done,
    input logic                  err,
    input logic                  req_valid,
    input logic [NUM_SPACES-1:0] ext_cs_n,
    input logic                  ext_rd_n,
    input logic [3:0]            ext_we_n
);

    // R11
    strobe_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cs_n != '1) |=> (ext_cs_n == '1));

    // R11
    single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));

    // R10
    read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rd_n |-> (ext_we_n == 4'hF));

    // R12
    strobe_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cs_n != '1) |-> busy);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !done && ext_cs_n == '1));

    // R12
    busy_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

endmodule

bind bus_lane_adapter bla_chk #(.NUM_SPACES(NUM_SPACES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .req_valid (req_valid),
    .ext_cs_n  (ext_cs_n),
    .ext_rd_n  (ext_rd_n),
    .ext_we_n  (ext_we_n)
);

// File: tb/bus_lane_adapter_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, a falling-edge device model that
// logs every external cycle and acknowledges after a programmable delay.
module bus_lane_adapter_tb_top;

    localparam int NS = 4;
    localparam int AW = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2*NS-1:0] cfg_width = 8'b01_10_01_00; // sp3 16, sp2 32, sp1 16, sp0 8
    logic          cfg_le_en = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_space = 2'd0;
    logic [31:0]   req_wdata = '0;
    logic          busy, done, err;
    logic [31:0]   rdata;
    logic [AW-1:0] ext_addr;
    logic [NS-1:0] ext_cs_n;
    logic          ext_rd_n;
    logic [3:0]    ext_we_n;
    logic [31:0]   ext_dout;
    logic [31:0]   ext_din = '0;
    logic          ext_ack = 1'b0;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    bus_lane_adapter #(.NUM_SPACES(NS), .ADDR_W(AW), .LE_SPACES(4'b1100)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_le_en(cfg_le_en),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_space(req_space), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
        .ext_we_n(ext_we_n), .ext_dout(ext_dout), .ext_din(ext_din), .ext_ack(ext_ack)
    );

    // Device model state and cycle log.
    int            dly = 0;
    int            ncnt = 0;
    bit            pend = 0;
    int            cnt = 0;
    int            pidx = 0;
    int            lg_n = 0;
    int            last_ack = 0;
    int            done_n = 0;
    int            done_gap = 0;
    logic [31:0]   rdq    [64];
    logic [AW-1:0] lg_addr[64];
    logic [3:0]    lg_we  [64];
    logic [31:0]   lg_dout[64];
    logic          lg_rd  [64];
    logic [NS-1:0] lg_cs  [64];
    int            lg_t   [64];

    // Log each strobe, acknowledge it after dly extra falling edges, track done.
    always @(negedge clk) begin
        ncnt = ncnt + 1;
        ext_ack = 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                ext_ack = 1'b1;
                ext_din = rdq[pidx];
                last_ack = ncnt;
                pend = 0;
            end else begin
                cnt = cnt - 1;
            end
        end
        if (ext_cs_n != '1 && lg_n < 64) begin
            lg_addr[lg_n] = ext_addr;
            lg_we[lg_n]   = ext_we_n;
            lg_dout[lg_n] = ext_dout;
            lg_rd[lg_n]   = ext_rd_n;
            lg_cs[lg_n]   = ext_cs_n;
            lg_t[lg_n]    = ncnt;
            pidx = lg_n;
            lg_n = lg_n + 1;
            pend = 1;
            cnt = dly;
        end
        if (done) begin
            done_n = done_n + 1;
            done_gap = ncnt - last_ack;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one request and wait for done or err.
    task automatic run(input logic [1:0] sp, input bit wr, input logic [1:0] sz,
                       input logic [AW-1:0] a, input logic [31:0] wd,
                       output int base, output bit got_err, output bit busy1,
                       output int dgap, output int dpulses);
        int d0;
        int t;
        base = lg_n;
        d0 = done_n;
        req_space = sp; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        busy1 = busy;
        got_err = err;
        t = 0;
        while (!(done || err) && t < 500) begin
            @(negedge clk);
            t++;
        end
        if (t >= 500) chk("R12", "request timeout", 32'(t), 32'd0);
        @(negedge clk);
        @(negedge clk);
        dgap = done_gap;
        dpulses = done_n - d0;
    endtask

    task automatic t_reset();
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "err", 32'(err), 32'd0);
        chk("R1", "cs_n", 32'(ext_cs_n), 32'hF);
        chk("R1", "rd_n", 32'(ext_rd_n), 32'd1);
        chk("R1", "we_n", 32'(ext_we_n), 32'hF);
    endtask

    task automatic t_x16_bytes();
        int b; bit e; bit bz; int g; int p;
        run(2'd1, 1'b1, 2'd0, 25'h100, 32'hA5, b, e, bz, g, p);
        chk("R2", "even byte cycles", 32'(lg_n - b), 32'd1);
        chk("R2", "even byte we_n", 32'(lg_we[b]), 32'hD);
        chk("R2", "even byte dout", lg_dout[b], 32'h0000_A500);
        chk("R2", "even byte cs_n", 32'(lg_cs[b]), 32'hD);
        run(2'd1, 1'b1, 2'd0, 25'h101, 32'h3C, b, e, bz, g, p);
        chk("R2", "odd byte addr", 32'(lg_addr[b]), 32'h101);
        chk("R10", "odd byte we_n", 32'(lg_we[b]), 32'hE);
        chk("R10", "odd byte dout", lg_dout[b], 32'h0000_003C);
    endtask

    task automatic t_x16_split();
        int b; bit e; bit bz; int g; int p;
        rdq[lg_n] = 32'hDEAD_BEEF;
        run(2'd1, 1'b0, 2'd1, 25'h200, 32'h0, b, e, bz, g, p);
        chk("R3", "word read cycles", 32'(lg_n - b), 32'd1);
        chk("R10", "word read rd_n/we_n", {27'd0, lg_rd[b], lg_we[b]}, 32'h0F);
        chk("R9", "word read rdata", rdata, 32'h0000_BEEF);
        run(2'd1, 1'b1, 2'd2, 25'h300, 32'h1234_5678, b, e, bz, g, p);
        chk("R3", "long write cycles", 32'(lg_n - b), 32'd2);
        chk("R3", "long first addr", 32'(lg_addr[b]), 32'h300);
        chk("R3", "long first data", lg_dout[b], 32'h0000_1234);
        chk("R3", "long second addr", 32'(lg_addr[b+1]), 32'h302);
        chk("R3", "long second data", lg_dout[b+1], 32'h0000_5678);
        chk("R10", "long we_n", 32'(lg_we[b+1]), 32'hC);
    endtask

    task automatic t_x8();
        int b; bit e; bit bz; int g; int p;
        rdq[lg_n]   = 32'hAAAA_AA11;
        rdq[lg_n+1] = 32'hBBBB_BB22;
        rdq[lg_n+2] = 32'hCCCC_CC33;
        rdq[lg_n+3] = 32'hDDDD_DD44;
        run(2'd0, 1'b0, 2'd2, 25'h40, 32'h0, b, e, bz, g, p);
        chk("R4", "long read cycles", 32'(lg_n - b), 32'd4);
        for (int k = 0; k < 4; k++)
            chk("R4", "long read addr", 32'(lg_addr[b+k]), 32'h40 + 32'(k));
        chk("R9", "byte-wise long rdata", rdata, 32'h1122_3344);
        chk("R9", "done one clock after last ack", 32'(g), 32'd1);
        chk("R9", "single done pulse", 32'(p), 32'd1);
        run(2'd0, 1'b1, 2'd1, 25'h52, 32'hCAFE, b, e, bz, g, p);
        chk("R4", "word cycles", 32'(lg_n - b), 32'd2);
        chk("R4", "word first", {lg_addr[b][7:0], lg_dout[b][23:0]}, 32'h52_0000CA);
        chk("R4", "word second", {lg_addr[b+1][7:0], lg_dout[b+1][23:0]}, 32'h53_0000FE);
        chk("R4", "word we_n", 32'(lg_we[b+1]), 32'hE);
        run(2'd0, 1'b1, 2'd0, 25'h57, 32'h99, b, e, bz, g, p);
        chk("R4", "odd byte lane 0", {lg_we[b], lg_dout[b][27:0]}, {4'hE, 28'h99});
    endtask

    task automatic t_x32();
        int b; bit e; bit bz; int g; int p;
        cfg_le_en = 1'b0;
        run(2'd2, 1'b1, 2'd0, 25'h1001, 32'h77, b, e, bz, g, p);
        chk("R5", "offset 1 we_n", 32'(lg_we[b]), 32'hB);
        chk("R5", "offset 1 dout", lg_dout[b], 32'h0077_0000);
        run(2'd2, 1'b1, 2'd2, 25'h2000, 32'hA1B2_C3D4, b, e, bz, g, p);
        chk("R5", "long cycles", 32'(lg_n - b), 32'd1);
        chk("R5", "long dout", lg_dout[b], 32'hA1B2_C3D4);
        chk("R10", "long we_n", 32'(lg_we[b]), 32'h0);
    endtask

    task automatic t_le();
        int b; bit e; bit bz; int g; int p;
        cfg_le_en = 1'b1;
        run(2'd2, 1'b1, 2'd2, 25'h2000, 32'hA1B2_C3D4, b, e, bz, g, p);
        chk("R6", "LE long dout", lg_dout[b], 32'hD4C3_B2A1);
        run(2'd2, 1'b1, 2'd0, 25'h1001, 32'h77, b, e, bz, g, p);
        chk("R6", "LE offset 1", {lg_we[b], lg_dout[b][27:0]}, {4'hD, 28'h7700});
        rdq[lg_n] = 32'h4433_2211;
        run(2'd2, 1'b0, 2'd2, 25'h3000, 32'h0, b, e, bz, g, p);
        chk("R6", "LE long rdata", rdata, 32'h1122_3344);
        run(2'd3, 1'b1, 2'd1, 25'h400, 32'hABCD, b, e, bz, g, p);
        chk("R6", "LE 16-bit word dout", lg_dout[b], 32'h0000_CDAB);
        run(2'd1, 1'b1, 2'd1, 25'h400, 32'hABCD, b, e, bz, g, p);
        chk("R7", "non-LE space word dout", lg_dout[b], 32'h0000_ABCD);
        cfg_le_en = 1'b0;
    endtask

    task automatic t_misalign();
        int b; bit e; bit bz; int g; int p;
        run(2'd1, 1'b0, 2'd1, 25'h201, 32'h0, b, e, bz, g, p);
        chk("R8", "odd word err/busy", {30'd0, e, bz}, 32'h2);
        chk("R8", "odd word no cycle", 32'(lg_n - b), 32'd0);
        run(2'd2, 1'b1, 2'd2, 25'h302, 32'h0, b, e, bz, g, p);
        chk("R8", "long not mod 4 err", 32'(e), 32'd1);
        chk("R8", "long not mod 4 no cycle", 32'(lg_n - b), 32'd0);
        run(2'd0, 1'b1, 2'd3, 25'h0, 32'h0, b, e, bz, g, p);
        chk("R8", "size 3 err/no cycle", {e, 31'(lg_n - b)}, 32'h8000_0000);
        chk("R8", "err one clock", 32'(err), 32'd0);
    endtask

    task automatic t_ack_wait();
        int b; bit e; bit bz; int g; int p;
        dly = 3;
        run(2'd1, 1'b1, 2'd2, 25'h500, 32'h0102_0304, b, e, bz, g, p);
        chk("R11", "strobe gap with delay 3", 32'(lg_t[b+1] - lg_t[b]), 32'd5);
        chk("R9", "done after delayed ack", 32'(g), 32'd1);
        dly = 0;
        run(2'd1, 1'b1, 2'd2, 25'h500, 32'h0102_0304, b, e, bz, g, p);
        chk("R11", "strobe gap with delay 0", 32'(lg_t[b+1] - lg_t[b]), 32'd2);
    endtask

    task automatic t_busy_ignore();
        int b; int d0;
        b = lg_n; d0 = done_n;
        rdq[lg_n] = 32'h5A; rdq[lg_n+1] = 32'h6B; rdq[lg_n+2] = 32'h7C; rdq[lg_n+3] = 32'h8D;
        req_space = 2'd0; req_write = 1'b0; req_size = 2'd2; req_addr = 25'h80;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12", "busy after accept", 32'(busy), 32'd1);
        @(negedge clk);
        req_space = 2'd1; req_write = 1'b1; req_size = 2'd0; req_addr = 25'h900;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t < 100 && !done; t++) @(negedge clk);
        chk("R12", "busy low at done", 32'(busy), 32'd0);
        repeat (4) @(negedge clk);
        chk("R12", "cycles while ignored", 32'(lg_n - b), 32'd4);
        chk("R12", "all reads on space 0", {28'd0, lg_cs[b+3]}, 32'hE);
        chk("R9", "rdata after ignored req", rdata, 32'h5A6B_7C8D);
        chk("R9", "done pulses", 32'(done_n - d0), 32'd1);
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_x16_bytes();
        t_x16_split();
        t_x8();
        t_x32();
        t_le();
        t_misalign();
        t_ack_wait();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule